// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two 32-bit binary floating-point values and returns a correctly rounded 32-bit result. Each word holds a sign in bit 31, an 8-bit exponent in bits 30:23 with a bias of 127, and a 23-bit fraction in bits 22:0 whose leading 1 is implied. An exponent of all ones marks infinity when the fraction is zero and NaN when it is not. An exponent of zero marks zero, and denormal encodings are treated as zero.

The datapath has three stages. The first classifies the operands and restores their hidden bits. The second orders them by magnitude and shifts the smaller one right by the exponent gap, keeping the bits that fall off as guard, round and sticky. The third adds or subtracts, normalises, rounds to nearest with ties to even and repacks. When the effective signs agree, normalisation is a single right shift. When they differ, it is a left shift by the leading-zero count. Infinities and NaNs take a separate path. An optional output register, chosen by a parameter, holds the result and its valid flag.

Top module: `fp32_addsub`

## Requirements
- R1: For two normal operands, `res` is the exact sum rounded to the nearest representable value, with ties going to the value whose fraction LSB (bit 0) is 0.
- R2: With `op_sub` = 1 the block returns `opa - opb`. This is the same as an addition with the sign bit (bit 31) of `opb` inverted.
- R3: The result does not depend on which port carries the larger-magnitude operand.
- R4: An exact zero produced by an effective subtraction is +0 (0x00000000). The sum of two zeros with the same effective sign keeps that sign.
- R5: A rounded result whose exponent reaches 255 gives an infinity with the result's sign (0x7F800000 or 0xFF800000).
- R6: A result below the smallest normal magnitude gives a zero signed like the larger-magnitude operand. `res` never carries exponent 0 with a nonzero fraction.
- R7: An operand with exponent field 0 counts as zero. The other operand then passes through unchanged (its sign is inverted when it is `opb` and `op_sub` = 1).
- R8: A NaN operand, or infinities of opposite effective sign, gives the quiet NaN 0x7FC00000.
- R9: An infinity combined with a finite value, or with an infinity of the same effective sign, gives that infinity.
- R10: With the output register present, `out_valid` follows `in_valid` one clock later. `res` loads only when `in_valid` is 1 and holds otherwise. Reset clears both to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands present this cycle |
| op_sub | input | 1 | 1 selects subtraction |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| out_valid | output | 1 | Result valid |
| res | output | 32 | Rounded sum or difference |

## Verification
The bench builds the block with its default format of an 8-bit exponent and a 23-bit fraction, and with the output register enabled. The real format lets the hand-worked vectors reach the cases that matter:
- exact half-ulp ties in both directions;
- a borrow that ripples through the guard bit and then rounds back up to 1.0;
- cancellation down to a single ulp;
- overflow at the largest finite value;
- underflow at the smallest normal value.

With the output register in place, the bench can also observe the valid timing, the hold behaviour and the reset state at the ports.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
   typedef enum logic [1:0] {
      FPC_ZERO = 2'd0,
      FPC_NORM = 2'd1,
      FPC_INF  = 2'd2,
      FPC_NAN  = 2'd3
   } fp_cls_e;
endpackage

// File: rtl/fpadd_unpack.sv
module fpadd_unpack
   import fpadd_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] op,
   input  logic                  flip,
   output logic                  sign,
   output logic [EXP_W-1:0]      exp_o,
   output logic [FRAC_W:0]       sig_o,
   output fp_cls_e               cls
);
   localparam logic [EXP_W-1:0] EXP_ONES = '1;

   logic [EXP_W-1:0]  e_fld;
   logic [FRAC_W-1:0] f_fld;

   assign e_fld = op[EXP_W+FRAC_W-1:FRAC_W];
   assign f_fld = op[FRAC_W-1:0];
   assign sign  = op[EXP_W+FRAC_W] ^ flip;

   always_comb begin
      exp_o = e_fld;
      sig_o = {1'b1, f_fld};
      if (e_fld == '0) begin
         // denormals are flushed: no hidden bit, no fraction
         cls   = FPC_ZERO;
         sig_o = '0;
      end else if (e_fld == EXP_ONES) begin
         cls = (f_fld == '0) ? FPC_INF : FPC_NAN;
      end else begin
         cls = FPC_NORM;
      end
   end
endmodule

// File: rtl/fpadd_align.sv
module fpadd_align #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic              a_sign,
   input  logic [EXP_W-1:0]  a_exp,
   input  logic [FRAC_W:0]   a_sig,
   input  logic              b_sign,
   input  logic [EXP_W-1:0]  b_exp,
   input  logic [FRAC_W:0]   b_sig,
   output logic              l_sign,
   output logic [EXP_W-1:0]  l_exp,
   output logic [FRAC_W:0]   l_sig,
   output logic              eff_sub,
   output logic [FRAC_W+3:0] s_aln
);
   localparam int SW = FRAC_W + 4;

   logic             a_big;
   logic             s_sign;
   logic [EXP_W-1:0] s_exp;
   logic [FRAC_W:0]  s_sig;
   logic [EXP_W-1:0] gap;
   logic [SW-1:0]    wide;
   logic [SW-1:0]    shifted;
   logic [SW-1:0]    keep_mask;
   logic             lost;

   assign a_big   = {a_exp, a_sig} >= {b_exp, b_sig};
   assign l_sign  = a_big ? a_sign : b_sign;
   assign l_exp   = a_big ? a_exp  : b_exp;
   assign l_sig   = a_big ? a_sig  : b_sig;
   assign s_sign  = a_big ? b_sign : a_sign;
   assign s_exp   = a_big ? b_exp  : a_exp;
   assign s_sig   = a_big ? b_sig  : a_sig;
   assign eff_sub = l_sign ^ s_sign;
   assign gap     = l_exp - s_exp;
   assign wide    = {s_sig, 3'b000};

   always_comb begin
      keep_mask = {SW{1'b1}} << gap;
      if (32'(gap) >= SW) begin
         shifted = '0;
         lost    = |wide;
      end else begin
         shifted = wide >> gap;
         lost    = |(wide & ~keep_mask);
      end
   end

   // fold everything shifted past the round bit into the sticky LSB
   assign s_aln = {shifted[SW-1:1], shifted[0] | lost};
endmodule

// File: rtl/fpadd_round.sv
module fpadd_round #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic                    l_sign,
   input  logic [EXP_W-1:0]        l_exp,
   input  logic [FRAC_W:0]         l_sig,
   input  logic                    eff_sub,
   input  logic [FRAC_W+3:0]       s_aln,
   output logic [EXP_W+FRAC_W:0]   res
);
   localparam int SW  = FRAC_W + 4;
   localparam int LZW = $clog2(SW + 1);
   localparam int EW  = EXP_W + 2;
   localparam logic [EW-1:0] EMAX_X = EW'((1 << EXP_W) - 1);

   logic [SW:0]       sum;
   logic [SW-1:0]     norm;
   logic [LZW-1:0]    lz;
   logic [EW-1:0]     le;
   logic [EW-1:0]     en;
   logic [FRAC_W+1:0] mant;
   logic [FRAC_W-1:0] frac;
   logic              inc;
   logic              under;

   assign le  = EW'(l_exp);
   assign sum = eff_sub ? ({1'b0, l_sig, 3'b000} - {1'b0, s_aln})
                        : ({1'b0, l_sig, 3'b000} + {1'b0, s_aln});

   always_comb begin
      lz = LZW'(SW);
      for (int i = 0; i < SW; i++) begin
         if (sum[i]) lz = LZW'(SW - 1 - i);
      end
   end

   always_comb begin
      under = 1'b0;
      if (sum[SW]) begin
         norm = {sum[SW:2], sum[1] | sum[0]};
         en   = le + EW'(1);
      end else begin
         norm  = sum[SW-1:0] << lz;
         en    = le - EW'(lz);
         under = EW'(lz) >= le;
      end
      inc  = norm[2] & (norm[1] | norm[0] | norm[3]);
      mant = {1'b0, norm[SW-1:3]} + {{(FRAC_W+1){1'b0}}, inc};
      if (mant[FRAC_W+1]) begin
         en   = en + EW'(1);
         frac = mant[FRAC_W:1];
      end else begin
         frac = mant[FRAC_W-1:0];
      end

      if (sum == '0)
         res = {~eff_sub & l_sign, {(EXP_W+FRAC_W){1'b0}}};
      else if (under)
         res = {l_sign, {(EXP_W+FRAC_W){1'b0}}};
      else if (en >= EMAX_X)
         res = {l_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      else
         res = {l_sign, en[EXP_W-1:0], frac};
   end
endmodule

// File: rtl/fp32_addsub.sv
module fp32_addsub
   import fpadd_pkg::*;
#(
   parameter int EXP_W   = 8,
   parameter int FRAC_W  = 23,
   parameter int OUT_REG = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic                  op_sub,
   input  logic [EXP_W+FRAC_W:0] opa,
   input  logic [EXP_W+FRAC_W:0] opb,
   output logic                  out_valid,
   output logic [EXP_W+FRAC_W:0] res
);
   localparam int W = EXP_W + FRAC_W + 1;
   localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

   if (EXP_W < 3)               begin : g_bad_exp  $error("EXP_W too small");  end
   if (FRAC_W < 2)              begin : g_bad_frac $error("FRAC_W too small"); end
   if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_reg $error("OUT_REG must be 0 or 1"); end

   logic [W-1:0]      op_v  [2];
   logic              flip_v[2];
   logic              sgn_v [2];
   logic [EXP_W-1:0]  exp_v [2];
   logic [FRAC_W:0]   sig_v [2];
   fp_cls_e           cls_v [2];

   assign op_v[0]   = opa;
   assign op_v[1]   = opb;
   assign flip_v[0] = 1'b0;
   assign flip_v[1] = op_sub;

   for (genvar k = 0; k < 2; k++) begin : g_unp
      fpadd_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp (
         .op(op_v[k]), .flip(flip_v[k]), .sign(sgn_v[k]),
         .exp_o(exp_v[k]), .sig_o(sig_v[k]), .cls(cls_v[k])
      );
   end

   logic              l_sign;
   logic [EXP_W-1:0]  l_exp;
   logic [FRAC_W:0]   l_sig;
   logic              eff_sub;
   logic [FRAC_W+3:0] s_aln;
   logic [W-1:0]      fin_res;
   logic [W-1:0]      nxt_res;

   fpadd_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_aln (
      .a_sign(sgn_v[0]), .a_exp(exp_v[0]), .a_sig(sig_v[0]),
      .b_sign(sgn_v[1]), .b_exp(exp_v[1]), .b_sig(sig_v[1]),
      .l_sign(l_sign), .l_exp(l_exp), .l_sig(l_sig),
      .eff_sub(eff_sub), .s_aln(s_aln)
   );

   fpadd_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_rnd (
      .l_sign(l_sign), .l_exp(l_exp), .l_sig(l_sig),
      .eff_sub(eff_sub), .s_aln(s_aln), .res(fin_res)
   );

   always_comb begin
      if (cls_v[0] == FPC_NAN || cls_v[1] == FPC_NAN ||
          (cls_v[0] == FPC_INF && cls_v[1] == FPC_INF && sgn_v[0] != sgn_v[1]))
         nxt_res = QNAN;
      else if (cls_v[0] == FPC_INF)
         nxt_res = {sgn_v[0], {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      else if (cls_v[1] == FPC_INF)
         nxt_res = {sgn_v[1], {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      else
         nxt_res = fin_res;
   end

   if (OUT_REG != 0) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            res       <= '0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) res <= nxt_res;
         end
      end
   end else begin : g_comb
      assign out_valid = in_valid;
      assign res       = nxt_res;
   end
endmodule

// File: rtl/fpadd_chk.sv
module fpadd_chk #(
   parameter int EXP_W   = 8,
   parameter int FRAC_W  = 23,
   parameter int OUT_REG = 1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  in_valid,
   input logic                  op_sub,
   input logic [EXP_W+FRAC_W:0] opa,
   input logic [EXP_W+FRAC_W:0] opb,
   input logic                  out_valid,
   input logic [EXP_W+FRAC_W:0] res
);
   localparam int MSB = EXP_W + FRAC_W;

   logic a_nan, b_nan, a_inf, b_inf, a_zero, b_norm, a_norm;
   logic r_nan, r_inf, r_denorm, b_zero;

   assign a_nan    = (&opa[MSB-1:FRAC_W]) && (|opa[FRAC_W-1:0]);
   assign b_nan    = (&opb[MSB-1:FRAC_W]) && (|opb[FRAC_W-1:0]);
   assign a_inf    = (&opa[MSB-1:FRAC_W]) && !(|opa[FRAC_W-1:0]);
   assign b_inf    = (&opb[MSB-1:FRAC_W]) && !(|opb[FRAC_W-1:0]);
   assign a_zero   = opa[MSB-1:FRAC_W] == '0;
   assign b_zero   = opb[MSB-1:FRAC_W] == '0;
   assign a_norm   = !a_zero && !(&opa[MSB-1:FRAC_W]);
   assign b_norm   = !b_zero && !(&opb[MSB-1:FRAC_W]);
   assign r_nan    = (&res[MSB-1:FRAC_W]) && (|res[FRAC_W-1:0]);
   assign r_inf    = (&res[MSB-1:FRAC_W]) && !(|res[FRAC_W-1:0]);
   assign r_denorm = (res[MSB-1:FRAC_W] == '0) && (|res[FRAC_W-1:0]);

   if (OUT_REG != 0) begin : g_seq
      // R10: valid tracks input one cycle later
      assert_valid_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      assert_valid_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
      assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> $stable(res));
      assert_nan_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && (a_nan || b_nan)) |=> r_nan);
      assert_inf_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && a_inf && (a_norm || b_norm || b_zero) && !b_inf) |=> (r_inf && res == $past(opa)));
      assert_zero_operand_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && b_zero && a_norm) |=> (res == $past(opa)));
      assert_no_denorm_R6: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> !r_denorm);
      assert_sub_nan_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && a_inf && b_inf && ((opa[MSB] ^ opb[MSB]) != op_sub)) |=> r_nan);
   end else begin : g_cmb
      assert_valid_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid == in_valid);
      assert_nan_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (a_nan || b_nan) |-> r_nan);
      assert_zero_operand_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (b_zero && a_norm) |-> res == opa);
      assert_no_denorm_R6: assert property (@(posedge clk) disable iff (!rst_n)
         !r_denorm);
      assert_inf_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (a_inf && b_norm) |-> res == opa);
      assert_sub_nan_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (a_inf && b_inf && ((opa[MSB] ^ opb[MSB]) != op_sub)) |-> r_nan);
   end
endmodule

bind fp32_addsub fpadd_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/fp32_addsub_tb_top.sv
`timescale 1ns/1ps
module fp32_addsub_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        op_sub = 1'b0;
   logic [31:0] opa = '0;
   logic [31:0] opb = '0;
   logic        out_valid;
   logic [31:0] res;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   fp32_addsub dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
      .opa(opa), .opb(opb), .out_valid(out_valid), .res(res)
   );

   // entry: {req, sub, a, b, expected}
   localparam int NV = 38;
   localparam logic [104:0] VEC [NV] = '{
      {8'd1, 1'b0, 32'h3F800000, 32'h3F800000, 32'h40000000},  // R1 1+1
      {8'd1, 1'b0, 32'h3F800000, 32'h40000000, 32'h40400000},  // R1 1+2
      {8'd1, 1'b0, 32'h3FC00000, 32'h40100000, 32'h40700000},  // R1 1.5+2.25
      {8'd1, 1'b0, 32'h3F800000, 32'h33800000, 32'h3F800000},  // R1 tie stays even
      {8'd1, 1'b0, 32'h3F800001, 32'h33800000, 32'h3F800002},  // R1 tie rounds to even
      {8'd1, 1'b0, 32'h3F800000, 32'h33C00000, 32'h3F800001},  // R1 above half
      {8'd1, 1'b0, 32'h3F800000, 32'h0DA24260, 32'h3F800000},  // R1 sticky only
      {8'd2, 1'b1, 32'h40400000, 32'h3F800000, 32'h40000000},  // R2 3-1
      {8'd2, 1'b1, 32'h3F800000, 32'h40400000, 32'hC0000000},  // R2 1-3
      {8'd2, 1'b1, 32'h3F800001, 32'h3F800000, 32'h34000000},  // R2 cancellation
      {8'd2, 1'b1, 32'h3F800000, 32'h33000000, 32'h3F800000},  // R2 borrow then round up
      {8'd2, 1'b1, 32'h80000000, 32'h00000000, 32'h80000000},  // R2 -0 minus +0
      {8'd3, 1'b0, 32'h33800000, 32'h3F800001, 32'h3F800002},  // R3 small first
      {8'd3, 1'b0, 32'h40000000, 32'h3F800000, 32'h40400000},  // R3 large first
      {8'd4, 1'b1, 32'h3F800000, 32'h3F800000, 32'h00000000},  // R4 x-x
      {8'd4, 1'b0, 32'hBF800000, 32'h3F800000, 32'h00000000},  // R4 -1+1
      {8'd4, 1'b0, 32'h80000000, 32'h80000000, 32'h80000000},  // R4 -0+-0
      {8'd4, 1'b0, 32'h00000000, 32'h80000000, 32'h00000000},  // R4 +0+-0
      {8'd5, 1'b0, 32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000},  // R5 +overflow
      {8'd5, 1'b0, 32'hFF7FFFFF, 32'hFF7FFFFF, 32'hFF800000},  // R5 -overflow
      {8'd6, 1'b1, 32'h00800000, 32'h00C00000, 32'h80000000},  // R6 underflow neg
      {8'd6, 1'b1, 32'h00C00000, 32'h00800000, 32'h00000000},  // R6 underflow pos
      {8'd7, 1'b0, 32'h00000001, 32'h3F800000, 32'h3F800000},  // R7 denorm a
      {8'd7, 1'b0, 32'h00000001, 32'h00000001, 32'h00000000},  // R7 two denorms
      {8'd7, 1'b0, 32'h3F800000, 32'h00400000, 32'h3F800000},  // R7 denorm b
      {8'd7, 1'b1, 32'h00000000, 32'h40000000, 32'hC0000000},  // R7 0-2
      {8'd8, 1'b0, 32'h7FC00000, 32'h3F800000, 32'h7FC00000},  // R8 nan a
      {8'd8, 1'b0, 32'h3F800000, 32'h7F800001, 32'h7FC00000},  // R8 nan b
      {8'd8, 1'b1, 32'h7F800000, 32'h7F800000, 32'h7FC00000},  // R8 inf-inf
      {8'd8, 1'b0, 32'h7F800000, 32'hFF800000, 32'h7FC00000},  // R8 inf+-inf
      {8'd8, 1'b0, 32'hFFC00000, 32'hFFC00000, 32'h7FC00000},  // R8 neg nans
      {8'd9, 1'b0, 32'h7F800000, 32'h3F800000, 32'h7F800000},  // R9 inf+1
      {8'd9, 1'b0, 32'hFF800000, 32'h3F800000, 32'hFF800000},  // R9 -inf+1
      {8'd9, 1'b1, 32'h3F800000, 32'h7F800000, 32'hFF800000},  // R9 1-inf
      {8'd9, 1'b0, 32'h7F800000, 32'h7F800000, 32'h7F800000},  // R9 inf+inf
      {8'd9, 1'b0, 32'h00000000, 32'hFF800000, 32'hFF800000},  // R9 0+-inf
      {8'd9, 1'b1, 32'hFF800000, 32'h7F800000, 32'hFF800000},  // R9 -inf-inf
      {8'd1, 1'b0, 32'h3F800000, 32'h3F800001, 32'h40000000}   // R1 1+1.0000001 tie even
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
      checks++;
      if (act !== exp_v) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R10 watchdog actual=timeout expected=finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] held;
      repeat (3) @(negedge clk);
      // R10 reset state
      check("R10 reset valid", {31'd0, out_valid}, 32'd0);
      check("R10 reset res", res, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         op_sub   = VEC[i][96];
         opa      = VEC[i][95:64];
         opb      = VEC[i][63:32];
         in_valid = 1'b1;
         @(negedge clk);
         check($sformatf("R%0d vec%0d", VEC[i][104:97], i), res, VEC[i][31:0]);
         check("R10 valid after input", {31'd0, out_valid}, 32'd1);
      end

      // R10: no input -> valid drops, result held
      held     = res;
      in_valid = 1'b0;
      opa      = 32'h40000000;
      opb      = 32'h40000000;
      @(negedge clk);
      check("R10 valid low", {31'd0, out_valid}, 32'd0);
      check("R10 hold", res, held);
      @(negedge clk);
      check("R10 hold 2", res, held);

      // R10: reset mid-run clears output
      in_valid = 1'b1;
      @(negedge clk);
      check("R10 load 2+2", res, 32'h40800000);
      rst_n    = 1'b0;
      in_valid = 1'b0;
      #1;
      check("R10 async reset res", res, 32'd0);
      check("R10 async reset valid", {31'd0, out_valid}, 32'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule